// File: doc/BRIEF.md
# Escape-Stuffing Byte Framer

This block sits on the transmit side of a byte-serial link and turns a stream of payload bytes into self-delimiting frames. Each frame opens with a two-byte pair, the escape code followed by the start-of-text code. It closes with the escape code followed by the end-of-text code. Between the two pairs the payload passes through unchanged, except that every payload byte equal to the escape code is sent twice. A receiver can therefore find frame boundaries from the escape pairs alone, and can restore the original payload by dropping one escape from each doubled pair.

Payload enters on a valid/ready port. The input side marks the final byte of a frame with `in_last`. A beat flagged `in_empty` carries no byte, so a zero-length frame can be requested. The framed bytes leave on a valid/ready port through a one-deep output register. Back-pressure rules: a byte is transferred on a rising edge where valid and ready are both high. Once `out_valid` is high, neither it nor `out_data` changes until `out_ready` accepts the byte. `in_ready` may depend on `in_valid`, `in_data` and `out_ready` in the same cycle. Upstream must keep a presented beat stable until it is accepted.

Top module: `escape_framer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 0 while no input is offered.
- R2: Every frame starts with byte 0x10 (escape) followed by 0x02 (start of text), and no payload beat is accepted while these two bytes are produced.
- R3: Every frame ends with 0x10 followed by 0x03 (end of text), emitted right after the byte accepted with `in_last`.
- R4: A payload byte equal to 0x10 is emitted as 0x10 0x10. `in_ready` stays low for exactly one extra cycle while the inserted escape is produced, and the byte is not lost.
- R5: Payload bytes other than 0x10 are emitted unchanged and in arrival order, one output byte each.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R7: A beat with `in_empty`=1 emits nothing and its `in_data` is ignored. With `in_last`=1 it closes the frame, so an empty frame yields exactly 0x10 0x02 0x10 0x03.
- R8: Frames sent back to back stay separate, and removing one escape from each doubled pair recovers each payload exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Payload beat offered |
| in_ready | output | 1 | Payload beat taken this cycle |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Beat is the last of its frame |
| in_empty | input | 1 | Beat carries no byte |
| out_valid | output | 1 | Framed byte available |
| out_ready | input | 1 | Downstream takes the framed byte |
| out_data | output | 8 | Framed byte |

## Verification
The hardest case to reach from the ports is an inserted escape that collides with output back-pressure. Here the stuffed byte is held in the output register while the doubled payload byte still waits upstream with `in_ready` low. The bench reaches it by throttling `out_ready` with a pseudo-random pattern during frames that contain runs of 0x10, including a frame whose last byte is 0x10. It checks both the byte stream and that each stalled byte stays unchanged. Under full throughput, the number of cycles each payload beat waits shows the single extra cycle taken by the inserted escape.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] DEF_ESC = 8'h10;
  localparam logic [BYTE_W-1:0] DEF_SOT = 8'h02;
  localparam logic [BYTE_W-1:0] DEF_EOT = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEAD,
    ST_BODY,
    ST_DUP,
    ST_TAIL_ESC,
    ST_TAIL_END
  } frm_state_t;
endpackage

// File: rtl/byte_slice.sv
module byte_slice #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cand_valid,
  input  logic [W-1:0] cand_data,
  output logic         can_load,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (can_load) begin
      out_valid <= cand_valid;
      if (cand_valid) out_data <= cand_data;
    end
  end

  // R6
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/stuff_seq.sv
module stuff_seq
  import framer_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] ESC = DEF_ESC,
  parameter logic [W-1:0] SOT = DEF_SOT,
  parameter logic [W-1:0] EOT = DEF_EOT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  input  logic         in_empty,
  input  logic         can_load,
  output logic         cand_valid,
  output logic [W-1:0] cand_data
);
  frm_state_t st, st_nxt;
  logic is_esc;

  assign is_esc = (in_data == ESC);

  always_comb begin
    st_nxt     = st;
    cand_valid = 1'b0;
    cand_data  = ESC;
    in_ready   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        cand_valid = in_valid;
        if (in_valid && can_load) st_nxt = ST_HEAD;
      end
      ST_HEAD: begin
        cand_valid = 1'b1;
        cand_data  = SOT;
        if (can_load) st_nxt = ST_BODY;
      end
      ST_BODY: begin
        if (in_valid) begin
          if (in_empty) begin
            in_ready = 1'b1;
            if (in_last) st_nxt = ST_TAIL_ESC;
          end else begin
            cand_valid = 1'b1;
            cand_data  = in_data;
            if (can_load) begin
              if (is_esc) st_nxt = ST_DUP;
              else begin
                in_ready = 1'b1;
                if (in_last) st_nxt = ST_TAIL_ESC;
              end
            end
          end
        end
      end
      ST_DUP: begin
        cand_valid = 1'b1;
        if (can_load) begin
          in_ready = 1'b1;
          st_nxt   = in_last ? ST_TAIL_ESC : ST_BODY;
        end
      end
      ST_TAIL_ESC: begin
        cand_valid = 1'b1;
        if (can_load) st_nxt = ST_TAIL_END;
      end
      ST_TAIL_END: begin
        cand_valid = 1'b1;
        cand_data  = EOT;
        if (can_load) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  // R2
  head_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && in_valid && can_load) |=> (st == ST_HEAD));

  // R2
  no_take_in_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_HEAD || st == ST_TAIL_ESC || st == ST_TAIL_END) |-> !in_ready);

  // R4
  esc_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY && in_valid && !in_empty && is_esc && can_load) |=> (st == ST_DUP));

  // R3
  tail_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL_ESC && can_load) |=> (st == ST_TAIL_END));
endmodule

// File: rtl/escape_framer.sv
module escape_framer
  import framer_pkg::*;
#(
  parameter logic [7:0] ESC_CODE = DEF_ESC,
  parameter logic [7:0] SOT_CODE = DEF_SOT,
  parameter logic [7:0] EOT_CODE = DEF_EOT
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_empty,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int unsigned W = BYTE_W;

  logic         can_load;
  logic         cand_valid;
  logic [W-1:0] cand_data;

  stuff_seq #(.W(W), .ESC(ESC_CODE), .SOT(SOT_CODE), .EOT(EOT_CODE)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_empty(in_empty),
    .can_load(can_load), .cand_valid(cand_valid), .cand_data(cand_data)
  );

  byte_slice #(.W(W)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .cand_valid(cand_valid), .cand_data(cand_data), .can_load(can_load),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: tb/test_escape_framer.sv
module test_escape_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_empty = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] pl[$];
  logic [7:0] expq[$];
  logic [7:0] got[$];
  int waits[$];
  bit throttle = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = 8'h00;

  always #4 clk = ~clk;

  escape_framer i_escape_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // output side: ready pattern, collection, stall stability (R6)
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = throttle ? lfsr[0] : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          chk(out_valid === 1'b1, "R6 valid held", int'(out_valid), 1);
          chk(out_data === prev_data, "R6 data held", int'(out_data), int'(prev_data));
        end
        if (out_valid && out_ready) got.push_back(out_data);
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic drive_beat(input logic [7:0] d, input bit last, input bit empty, output int cyc);
    bit hs;
    cyc = 0;
    hs  = 1'b0;
    while (!hs) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d; in_last = last; in_empty = empty;
      #3;
      hs = in_ready;
      @(posedge clk);
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_empty = 1'b0;
  endtask

  // builds the encoded stream of pl onto expq
  task automatic add_expected();
    expq.push_back(8'h10); expq.push_back(8'h02);
    foreach (pl[i]) begin
      if (pl[i] == 8'h10) expq.push_back(8'h10);
      expq.push_back(pl[i]);
    end
    expq.push_back(8'h10); expq.push_back(8'h03);
  endtask

  task automatic send_frame(input bit empty_end);
    int c;
    add_expected();
    waits.delete();
    foreach (pl[i]) begin
      drive_beat(pl[i], (i == pl.size() - 1) && !empty_end, 1'b0, c);
      waits.push_back(c);
    end
    if (empty_end || pl.size() == 0) drive_beat(8'h10, 1'b1, 1'b1, c);
  endtask

  task automatic compare_stream(input string req);
    int guard = 0;
    while (got.size() < expq.size() && guard < 2000) begin
      @(posedge clk); guard++;
    end
    repeat (6) @(posedge clk);
    chk(got.size() == expq.size(), {req, " length"}, got.size(), expq.size());
    foreach (expq[i])
      if (i < got.size())
        chk(got[i] === expq[i], {req, " byte"}, int'(got[i]), int'(expq[i]));
    got.delete(); expq.delete();
  endtask

  task automatic t_reset();
    #1;
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready === 1'b0, "R1 in_ready", int'(in_ready), 0);
  endtask

  task automatic t_plain();
    throttle = 1'b0;
    pl = '{8'h41, 8'h42, 8'h00, 8'hFF};
    send_frame(1'b0);
    compare_stream("R2 R3 R5 plain frame");
  endtask

  task automatic t_escape_timing();
    throttle = 1'b0;
    pl = '{8'h55, 8'h10, 8'h66, 8'h10, 8'h10, 8'h77};
    send_frame(1'b0);
    for (int i = 1; i < pl.size(); i++)
      chk(waits[i] == ((pl[i] == 8'h10) ? 2 : 1), "R4 in_ready stall cycles", waits[i],
          (pl[i] == 8'h10) ? 2 : 1);
    compare_stream("R4 doubled escape");
  endtask

  task automatic t_empty();
    throttle = 1'b0;
    pl.delete();
    send_frame(1'b1);
    compare_stream("R7 empty frame");
    pl = '{8'h31, 8'h32};
    send_frame(1'b1);
    compare_stream("R7 empty beat terminator");
  endtask

  task automatic t_backpressure();
    throttle = 1'b1;
    pl = '{8'h10, 8'h10, 8'hA5, 8'h10, 8'h5A, 8'h03, 8'h02, 8'h10};
    send_frame(1'b0);
    compare_stream("R6 R4 throttled frame");
    throttle = 1'b0;
  endtask

  task automatic t_back_to_back();
    logic [7:0] orig[$];
    logic [7:0] rec[$];
    int k;
    throttle = 1'b1;
    pl = '{8'h10, 8'h20}; orig = pl; send_frame(1'b0);
    pl = '{8'h30, 8'h10}; foreach (pl[i]) orig.push_back(pl[i]); send_frame(1'b0);
    begin
      int guard = 0;
      while (got.size() < expq.size() && guard < 2000) begin
        @(posedge clk); guard++;
      end
    end
    repeat (6) @(posedge clk);
    // strip delimiters and one escape of each doubled pair
    k = 0;
    while (k < got.size()) begin
      if (got[k] == 8'h10 && k + 1 < got.size()) begin
        if (got[k+1] == 8'h10) rec.push_back(8'h10);
        k += 2;
      end else begin
        rec.push_back(got[k]);
        k++;
      end
    end
    chk(rec.size() == orig.size(), "R8 recovered length", rec.size(), orig.size());
    foreach (orig[i])
      if (i < rec.size())
        chk(rec[i] === orig[i], "R8 recovered byte", int'(rec[i]), int'(orig[i]));
    compare_stream("R8 two frames");
    throttle = 1'b0;
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_plain();
    t_escape_timing();
    t_empty();
    t_backpressure();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule